// File: doc/BRIEF.md
# Four-Way Packet Distribution Router

This block accepts one 8-bit packet per clock from a single upstream source and delivers each packet to one of four output ports. The two lowest bits of a packet name its destination port and the upper six bits are payload carried along untouched. An accepted packet is first captured in a staging register. On the next clock a demultiplexer writes it into the queue of its destination port. Each port has its own first-in first-out queue, so a slow consumer on one port does not delay traffic for the other ports. The one exception is a packet that is blocked in the staging register.

On the output side a rotating arbiter picks at most one port per clock whose queue holds data and whose consumer is ready. It presents the head packet of that queue on the port's data bus with a valid strobe, and the packet is removed on that clock edge. When the destination queue of the staged packet is full, the block raises a stall flag upstream and keeps the staged packet until space frees.

Top module: `pkt_dist_router`

## Requirements
- R1: A synchronous active-high reset empties all four queues, clears the staging register and sets the arbiter start point to port 0. On the first clock after reset no `out_valid` bit is high and `stall` is low.
- R2: A packet whose bits [1:0] are 00, 01, 10 or 11 is delivered on port 0, 1, 2 or 3 respectively, with all 8 bits unchanged, and on no other port.
- R3: A packet is taken only on a rising edge where `in_en` is high and `stall` is low. While `in_en` is low, no new packet reaches any output, whatever `in_data` carries.
- R4: Packets bound for the same port leave that port in the order they were accepted.
- R5: Each port queue holds 8 packets. With a consumer that is not ready, 8 packets fill the queue and a 9th waits in the staging register with `stall` high. Once the queue drains, all 9 packets are delivered in order and `stall` falls.
- R6: In any cycle at most one `out_valid` bit is high, and only on a port whose `out_ready` is high and whose queue holds data. A packet leaves its queue on the clock edge where its `out_valid` is high.
- R7: The arbiter begins each search at the port after the one last granted, in increasing port order with wrap-around. Ports with nothing to send, or with `out_ready` low, are skipped within the same cycle. With all four ports loaded the grants run 0,1,2,3,0,... on consecutive cycles. With only ports 0 and 2 loaded they run 0,2,0,2 with no idle cycle.
- R8: While `stall` is high the staged packet is kept, and `in_data` and `in_en` have no effect on what is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_en | input | 1 | Packet strobe from upstream |
| in_data | input | 8 | Packet: bits [1:0] destination, bits [7:2] payload |
| stall | output | 1 | High while the staged packet cannot enter its full queue |
| out_valid | output | 4 | One bit per port: head packet presented this cycle |
| out_ready | input | 4 | One bit per port: consumer takes a presented packet |
| out_data | output | 32 | Port n data on bits [8n+7:8n] |

## Verification
The bench builds the block with its default values: four ports selected by a 2-bit field and a queue depth of 8. At this depth a full queue takes only eight packets, which puts the stall path within reach of a short test: a ninth packet sitting in the staging register while new input is offered and ignored. With four ports, a single burst touches every arbitration position, so the bench can check both full rotation and the skipping of empty ports cycle by cycle.

// File: rtl/pkt_router_pkg.sv
package pkt_router_pkg;
    localparam int PKT_W      = 8;
    localparam int DEST_W     = 2;
    localparam int NPORT      = 1 << DEST_W;
    localparam int PAYLOAD_W  = PKT_W - DEST_W;
    localparam int QUEUE_DEPTH = 8;

    typedef struct packed {
        logic [PAYLOAD_W-1:0] payload;
        logic [DEST_W-1:0]    dest;
    } pkt_t;
endpackage

// File: rtl/pkt_stage.sv
module pkt_stage
    import pkt_router_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load_en,
    input  logic hold,
    input  pkt_t pkt_in,
    output pkt_t pkt_q,
    output logic vld_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pkt_q <= '0;
            vld_q <= 1'b0;
        end else if (!hold) begin
            vld_q <= load_en;
            if (load_en) pkt_q <= pkt_in;
        end
    end
endmodule

// File: rtl/port_queue.sv
module port_queue #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             full,
    output logic             empty
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW:0] wr_ptr, rd_ptr;

    assign empty = (wr_ptr == rd_ptr);
    assign full  = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
    assign head  = mem[rd_ptr[AW-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push && !full) begin
                mem[wr_ptr[AW-1:0]] <= push_data;
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (pop && !empty) rd_ptr <= rd_ptr + 1'b1;
        end
    end
endmodule

// File: rtl/rr_drain.sv
module rr_drain #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;

    logic [PW-1:0] start_q;
    logic [PW-1:0] win_idx;
    logic          found;

    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        grant   = '0;
        for (int off = 0; off < N; off++) begin
            logic [PW-1:0] idx;
            idx = start_q + PW'(off);
            if (!found && req[idx]) begin
                found   = 1'b1;
                win_idx = idx;
            end
        end
        if (found) grant[win_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)        start_q <= '0;
        else if (found) start_q <= win_idx + 1'b1;
    end
endmodule

// File: rtl/pkt_dist_router.sv
module pkt_dist_router
    import pkt_router_pkg::*;
#(
    parameter int DEPTH = QUEUE_DEPTH
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_en,
    input  logic [PKT_W-1:0]       in_data,
    output logic                   stall,
    output logic [NPORT-1:0]       out_valid,
    input  logic [NPORT-1:0]       out_ready,
    output logic [NPORT*PKT_W-1:0] out_data
);
    pkt_t             stage_pkt;
    logic             stage_vld;
    logic [NPORT-1:0] q_full, q_empty, q_push, q_req, grant;

    assign stall = stage_vld && q_full[stage_pkt.dest];

    pkt_stage u_stage (
        .clk    (clk),
        .rst    (rst),
        .load_en(in_en),
        .hold   (stall),
        .pkt_in (pkt_t'(in_data)),
        .pkt_q  (stage_pkt),
        .vld_q  (stage_vld)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        logic [PKT_W-1:0] head;

        assign q_push[p] = stage_vld && (stage_pkt.dest == DEST_W'(p)) && !q_full[p];
        assign q_req[p]  = !q_empty[p] && out_ready[p];
        assign out_data[p*PKT_W +: PKT_W] = head;

        port_queue #(.DEPTH(DEPTH), .WIDTH(PKT_W)) u_queue (
            .clk      (clk),
            .rst      (rst),
            .push     (q_push[p]),
            .push_data(stage_pkt),
            .pop      (grant[p]),
            .head     (head),
            .full     (q_full[p]),
            .empty    (q_empty[p])
        );
    end

    rr_drain #(.N(NPORT)) u_arb (
        .clk  (clk),
        .rst  (rst),
        .req  (q_req),
        .grant(grant)
    );

    assign out_valid = grant;
endmodule

// File: rtl/pkt_dist_router_chk.sv
module pkt_dist_router_chk #(
    parameter int NP = 4,
    parameter int PW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          in_en,
    input logic          stall,
    input logic [NP-1:0] out_valid,
    input logic [NP-1:0] out_ready,
    input logic [PW-1:0] stage_bits
);
    p_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (out_valid == '0 && !stall));

    p_one_grant_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(out_valid));

    p_valid_ready_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid & ~out_ready) == '0);

    p_stall_src_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(stall) |-> $past(in_en));

    p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
        stall |=> $stable(stage_bits));
endmodule

bind pkt_dist_router pkt_dist_router_chk #(.NP(pkt_router_pkg::NPORT), .PW(pkt_router_pkg::PKT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_en     (in_en),
    .stall     (stall),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .stage_bits(stage_pkt)
);

// File: tb/pkt_dist_router_tb_top.sv
module pkt_dist_router_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_en = 1'b0;
    logic [7:0]  in_data = '0;
    logic        stall;
    logic [3:0]  out_valid;
    logic [3:0]  out_ready = '0;
    logic [31:0] out_data;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int delivered = 0;
    bit done = 0;

    logic [7:0] q0[$], q1[$], q2[$], q3[$];
    int glog_port[$];
    int glog_cyc[$];

    always #10 clk = ~clk;

    pkt_dist_router dut_i (
        .clk(clk), .rst(rst), .in_en(in_en), .in_data(in_data), .stall(stall),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic push_exp(input logic [7:0] p);
        case (p[1:0])
            2'd0: q0.push_back(p);
            2'd1: q1.push_back(p);
            2'd2: q2.push_back(p);
            default: q3.push_back(p);
        endcase
    endtask

    function automatic int qsize(input int p);
        case (p)
            0: return q0.size();
            1: return q1.size();
            2: return q2.size();
            default: return q3.size();
        endcase
    endfunction

    function automatic logic [7:0] qpop(input int p);
        case (p)
            0: return q0.pop_front();
            1: return q1.pop_front();
            2: return q2.pop_front();
            default: return q3.pop_front();
        endcase
    endfunction

    // driver: packet is taken at the posedge following a cycle with stall low
    task automatic send(input logic [7:0] p);
        @(negedge clk);
        in_en = 1'b1;
        in_data = p;
        #1;
        while (stall) begin
            @(negedge clk);
            #1;
        end
        push_exp(p);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_en = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_en = 1'b0;
        repeat (2) @(negedge clk);
        q0.delete(); q1.delete(); q2.delete(); q3.delete();
        glog_port.delete(); glog_cyc.delete();
        rst = 1'b0;
    endtask

    always @(posedge clk) cyc++;

    // monitor: compares each presented packet with the scoreboard
    always @(negedge clk) begin
        #5;
        if (!rst) begin
            check($countones(out_valid) <= 1, "R6", "grants per cycle", $countones(out_valid), 1);
            for (int p = 0; p < 4; p++) begin
                if (out_valid[p]) begin
                    logic [7:0] got;
                    got = out_data[p*8 +: 8];
                    delivered++;
                    glog_port.push_back(p);
                    glog_cyc.push_back(cyc);
                    check(out_ready[p], "R6", "valid without ready", 0, 1);
                    if (qsize(p) == 0) begin
                        check(1'b0, "R2", "unexpected packet on port", int'(got), -1);
                    end else begin
                        logic [7:0] e;
                        e = qpop(p);
                        check(got == e, "R4", "packet value/order", int'(got), int'(e));
                    end
                end
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int base;
        do_reset();
        out_ready = 4'hF;
        #1;
        // R1 reset state
        check(out_valid == 4'h0, "R1", "out_valid after reset", out_valid, 0);
        check(stall == 1'b0, "R1", "stall after reset", stall, 0);

        // R2 decode across all ports, mixed payloads
        for (int k = 0; k < 16; k++) send(8'((k * 37) << 2) | 8'(k % 4));
        for (int k = 0; k < 8; k++) send(8'hA0 | 8'(3 - (k % 4)));
        idle(8);
        for (int p = 0; p < 4; p++)
            check(qsize(p) == 0, "R2", "undelivered packets", qsize(p), 0);

        // R3 in_en low: nothing reaches the outputs
        base = delivered;
        @(negedge clk);
        for (int k = 0; k < 10; k++) begin
            in_data = 8'(k * 29 + 1);
            @(negedge clk);
        end
        check(delivered == base, "R3", "packets while in_en low", delivered - base, 0);

        // R5 fill port 1, ninth packet stalls
        out_ready = 4'b1101;
        for (int k = 0; k < 9; k++) send(8'((k + 1) << 2) | 8'd1);
        @(negedge clk);
        in_en = 1'b0;
        #1;
        check(stall == 1'b1, "R5", "stall with full queue", stall, 1);
        // R8 offered input while stalled is ignored
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            in_en = 1'b1;
            in_data = 8'hFD;
            #1;
            check(stall == 1'b1, "R8", "stall held", stall, 1);
        end
        @(negedge clk);
        in_en = 1'b0;
        out_ready = 4'hF;
        repeat (14) @(negedge clk);
        #1;
        check(q1.size() == 0, "R5", "port 1 drained", q1.size(), 0);
        check(stall == 1'b0, "R5", "stall released", stall, 0);

        // R7 full rotation after reset
        do_reset();
        out_ready = 4'h0;
        for (int k = 0; k < 8; k++) send(8'((k + 8) << 2) | 8'(3 - (k % 4)));
        idle(4);
        out_ready = 4'hF;
        repeat (10) @(negedge clk);
        check(glog_port.size() == 8, "R7", "grant count", glog_port.size(), 8);
        for (int k = 0; k < 8 && k < glog_port.size(); k++) begin
            check(glog_port[k] == k % 4, "R7", "rotation order", glog_port[k], k % 4);
            if (k > 0)
                check(glog_cyc[k] == glog_cyc[k-1] + 1, "R7", "back-to-back grant",
                      glog_cyc[k] - glog_cyc[k-1], 1);
        end

        // R7 skipping empty ports
        do_reset();
        out_ready = 4'h0;
        send(8'h40); send(8'h52); send(8'h64); send(8'h76);
        idle(4);
        out_ready = 4'hF;
        repeat (8) @(negedge clk);
        check(glog_port.size() == 4, "R7", "skip grant count", glog_port.size(), 4);
        for (int k = 0; k < 4 && k < glog_port.size(); k++) begin
            check(glog_port[k] == (k % 2) * 2, "R7", "skip order", glog_port[k], (k % 2) * 2);
            if (k > 0)
                check(glog_cyc[k] == glog_cyc[k-1] + 1, "R7", "no idle slot",
                      glog_cyc[k] - glog_cyc[k-1], 1);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule